// File: doc/BRIEF.md
# Periodic Rate and Square-Wave Generator

The block divides a 32768 Hz time-base enable into a selectable set of binary rates. It drives a square-wave output pin and a single-cycle periodic-event strobe. Each strobe sets a sticky periodic flag, which software clears by reading it. A 4-bit rate code picks the divided frequency. Two low codes are aliases of mid-range rates, so the sixteen codes yield thirteen distinct frequencies. An override bit routes the raw time base to the pin and suppresses periodic events entirely.

Configuration arrives through a single register write. `cfg_wdata[3:0]` is the rate code, `cfg_wdata[4]` enables the square wave and `cfg_wdata[5]` is the override. The divider is a free-running counter advanced by the time-base enable. A rate change therefore never restarts it.

Top module: `rpg_rate_gen`

## Requirements
- R1: After reset the rate code, wave enable and override are 0, and the flag is 0. `sq_out`, `per_strobe` and `per_flag` are all low.
- R2: For rate codes 3 to 15 the strobe period is 2^(code-1) time-base ticks (8192 Hz at code 3 down to 2 Hz at code 15). With the wave enabled, `sq_out` has the same period and is high for exactly half of it.
- R3: Code 1 produces the same period and waveform as code 8 (256 Hz). Code 2 produces the same period and waveform as code 9 (128 Hz).
- R4: With rate code 0 no strobe fires, `sq_out` never goes high and the flag is not set.
- R5: With the override bit set, `sq_out` follows the time base, delayed by one clock: one high clock per tick. The rate code has no effect on it.
- R6: With the override bit set, `per_strobe` never fires and `per_flag` is never set by the block.
- R7: With both the wave enable and the override at 0, `sq_out` stays low, while strobes continue at the selected rate.
- R8: `per_strobe` lasts one clock and coincides with the rising edge of the selected square wave. The following cycle `per_flag` is 1.
- R9: A one-clock `flag_rd` clears `per_flag` at the next edge. When a strobe falls in that same cycle, the flag stays set.
- R10: A rate change does not restart the divider. The first strobe under the new code comes at the next rising edge of the new tap, no later than one new period after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_32k | input | 1 | Time-base enable, one pulse per 32768 Hz period |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 6 | [3:0] rate code, [4] wave enable, [5] override |
| flag_rd | input | 1 | Flag read; clears the flag |
| sq_out | output | 1 | Square-wave output |
| per_strobe | output | 1 | One-clock periodic event |
| per_flag | output | 1 | Sticky periodic flag (read value) |

## Verification
A new periodic event and a flag read can land in the same clock, and then the set must win over the clear. The bench detects a strobe at the falling clock edge and raises `flag_rd` within that same cycle. It then expects the flag to read 1. A second read in a quiet cycle must then clear the flag to 0.

// File: rtl/rpg_pkg.sv
package rpg_pkg;

   localparam int unsigned RPG_CODE_W = 4;

   typedef struct packed {
      logic                  ovr;
      logic                  wave_en;
      logic [RPG_CODE_W-1:0] rate;
   } rpg_cfg_t;

   localparam int unsigned RPG_CFG_W = $bits(rpg_cfg_t);

   // Counter bit whose period matches a rate code; codes 1 and 2 alias 8 and 9.
   function automatic int unsigned rpg_tap_of(input int unsigned code);
      int unsigned eff;
      eff = (code == 1) ? 8 : (code == 2) ? 9 : code;
      return (eff < 2) ? 0 : eff - 2;
   endfunction

endpackage

// File: rtl/rpg_divider.sv
module rpg_divider #(
   parameter int unsigned DIV_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   output logic [DIV_W-1:0] cnt
);

   generate
      if (DIV_W < 2) begin : g_bad_width
         $error("rpg_divider: DIV_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (tick) begin
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/rpg_tap_sel.sv
module rpg_tap_sel
   import rpg_pkg::*;
#(
   parameter int unsigned DIV_W  = 15,
   parameter int unsigned CODE_W = RPG_CODE_W
) (
   input  logic [DIV_W-1:0]  cnt,
   input  logic              tick,
   input  logic [CODE_W-1:0] code,
   output logic              tap_lvl,
   output logic              tap_rise
);

   localparam int unsigned NCODES = 1 << CODE_W;

   logic [NCODES-1:0] lvl_v;
   logic [NCODES-1:0] rise_v;

   generate
      for (genvar gi = 0; gi < NCODES; gi++) begin : g_code
         localparam int unsigned TAP = rpg_tap_of(gi);
         if (gi == 0) begin : g_off
            assign lvl_v[gi]  = 1'b0;
            assign rise_v[gi] = 1'b0;
         end else if (TAP >= DIV_W || TAP == 0) begin : g_bad
            $error("rpg_tap_sel: tap out of divider range");
            assign lvl_v[gi]  = 1'b0;
            assign rise_v[gi] = 1'b0;
         end else begin : g_tap
            // Bit TAP rises on the tick where all lower bits are ones and it is zero.
            assign lvl_v[gi]  = cnt[TAP];
            assign rise_v[gi] = tick & (&cnt[TAP-1:0]) & ~cnt[TAP];
         end
      end
   endgenerate

   assign tap_lvl  = lvl_v[code];
   assign tap_rise = rise_v[code];

endmodule

// File: rtl/rpg_flag.sv
module rpg_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);

   // A set in the same cycle as a clear wins, so no event is lost.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag <= 1'b0;
      end else if (set) begin
         flag <= 1'b1;
      end else if (clr) begin
         flag <= 1'b0;
      end
   end

endmodule

// File: rtl/rpg_rate_gen.sv
module rpg_rate_gen
   import rpg_pkg::*;
#(
   parameter int unsigned DIV_W  = 15,
   parameter int unsigned CODE_W = RPG_CODE_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_32k,
   input  logic                 cfg_we,
   input  logic [RPG_CFG_W-1:0] cfg_wdata,
   input  logic                 flag_rd,
   output logic                 sq_out,
   output logic                 per_strobe,
   output logic                 per_flag
);

   localparam int unsigned MAX_TAP = (1 << CODE_W) - 3;

   generate
      if (CODE_W != RPG_CODE_W) begin : g_bad_code
         $error("rpg_rate_gen: CODE_W must match the package rate field");
      end
      if (DIV_W <= MAX_TAP) begin : g_bad_div
         $error("rpg_rate_gen: DIV_W too small for the slowest rate");
      end
   endgenerate

   rpg_cfg_t          cfg_q;
   logic              ovr_q;
   logic              wave_q;
   logic [CODE_W-1:0] rate_q;
   logic [DIV_W-1:0]  cnt;
   logic              tick_q;
   logic              tap_lvl;
   logic              tap_rise;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (cfg_we) begin
         cfg_q <= rpg_cfg_t'(cfg_wdata);
      end
   end

   assign ovr_q  = cfg_q.ovr;
   assign wave_q = cfg_q.wave_en;
   assign rate_q = cfg_q.rate;

   rpg_divider #(.DIV_W(DIV_W)) i_div (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick_32k),
      .cnt   (cnt)
   );

   rpg_tap_sel #(.DIV_W(DIV_W), .CODE_W(CODE_W)) i_tap (
      .cnt      (cnt),
      .tick     (tick_32k),
      .code     (rate_q),
      .tap_lvl  (tap_lvl),
      .tap_rise (tap_rise)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tick_q     <= 1'b0;
         per_strobe <= 1'b0;
      end else begin
         tick_q     <= tick_32k;
         per_strobe <= tap_rise & ~ovr_q;
      end
   end

   always_comb begin
      if (ovr_q) begin
         sq_out = tick_q;
      end else if (wave_q) begin
         sq_out = tap_lvl;
      end else begin
         sq_out = 1'b0;
      end
   end

   rpg_flag i_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (per_strobe),
      .clr   (flag_rd),
      .flag  (per_flag)
   );

endmodule

// File: rtl/rpg_rate_gen_chk.sv
module rpg_rate_gen_chk #(
   parameter int unsigned CODE_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flag_rd,
   input logic              sq_out,
   input logic              per_strobe,
   input logic              per_flag,
   input logic              ovr_q,
   input logic              wave_q,
   input logic [CODE_W-1:0] rate_q
);

   assert_no_event_code0_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_q == '0) |=> !per_strobe);

   assert_no_event_override_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_q |=> !per_strobe);

   assert_wave_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!wave_q && !ovr_q) |-> !sq_out);

   assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      per_strobe |=> !per_strobe);

   assert_strobe_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      per_strobe |=> per_flag);

   assert_strobe_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (per_strobe && wave_q && !ovr_q) |-> sq_out);

   assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_rd && !per_strobe) |=> !per_flag);

endmodule

bind rpg_rate_gen rpg_rate_gen_chk #(.CODE_W(CODE_W)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .flag_rd    (flag_rd),
   .sq_out     (sq_out),
   .per_strobe (per_strobe),
   .per_flag   (per_flag),
   .ovr_q      (ovr_q),
   .wave_q     (wave_q),
   .rate_q     (rate_q)
);

// File: tb/test_rpg_rate_gen.sv
`timescale 1ns/1ps
module test_rpg_rate_gen;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_32k = 1'b0;
   logic       cfg_we = 1'b0;
   logic [5:0] cfg_wdata = '0;
   logic       flag_rd = 1'b0;
   logic       sq_out;
   logic       per_strobe;
   logic       per_flag;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   initial begin
      forever begin
         @(negedge clk);
         tick_32k = ~tick_32k;
      end
   end

   rpg_rate_gen i_rpg_rate_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_32k   (tick_32k),
      .cfg_we     (cfg_we),
      .cfg_wdata  (cfg_wdata),
      .flag_rd    (flag_rd),
      .sq_out     (sq_out),
      .per_strobe (per_strobe),
      .per_flag   (per_flag)
   );

   // Tick every two clocks: period in clocks is 2 * 2^(eff-1).
   function automatic int exp_period(input int code);
      int eff;
      eff = (code == 1) ? 8 : (code == 2) ? 9 : code;
      return 1 << eff;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic write_cfg(input bit ovr, input bit en, input int code);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_wdata = {ovr, en, 4'(code)};
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   task automatic read_flag();
      @(negedge clk);
      flag_rd = 1'b1;
      @(negedge clk);
      flag_rd = 1'b0;
   endtask

   // Waits for a strobe, then returns the clocks to the next one and sq_out high count.
   task automatic measure(output int period, output int high);
      int guard = 0;
      while (!per_strobe && guard < 70000) begin
         @(negedge clk);
         guard++;
      end
      period = 0;
      high   = 0;
      do begin
         if (sq_out) high++;
         period++;
         @(negedge clk);
      end while (!per_strobe && period < 70000);
   endtask

   task automatic run_code(input int code, input bit en, input string req);
      int p, h, e;
      write_cfg(1'b0, en, code);
      measure(p, h);
      e = exp_period(code);
      chk(p == e, {req, " period"}, p, e);
      chk(h == (en ? e / 2 : 0), {req, " high time"}, h, en ? e / 2 : 0);
   endtask

   task automatic quiet_window(input int n, input string req, input bit expect_sq_half);
      int strobes = 0, high = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (per_strobe) strobes++;
         if (sq_out) high++;
      end
      chk(strobes == 0, {req, " strobes"}, strobes, 0);
      chk(high == (expect_sq_half ? n / 2 : 0), {req, " sq high"}, high,
          expect_sq_half ? n / 2 : 0);
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int p, h, n, code, wait_n;
      void'($urandom(32'd2024));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(sq_out == 1'b0, "R1 sq_out", int'(sq_out), 0);
      chk(per_strobe == 1'b0, "R1 per_strobe", int'(per_strobe), 0);
      chk(per_flag == 1'b0, "R1 per_flag", int'(per_flag), 0);
      quiet_window(40, "R1", 1'b0);

      // R2 every distinct code, fastest first
      for (int c = 3; c <= 15; c++) run_code(c, 1'b1, "R2");

      // R3 aliased codes
      run_code(1, 1'b1, "R3 code1");
      run_code(8, 1'b1, "R3 code8");
      run_code(2, 1'b1, "R3 code2");
      run_code(9, 1'b1, "R3 code9");

      // R7 enable off: strobes continue, pin low
      run_code(5, 1'b0, "R7");

      // R4 code 0
      read_flag();
      write_cfg(1'b0, 1'b1, 0);
      read_flag();
      quiet_window(300, "R4", 1'b0);
      chk(per_flag == 1'b0, "R4 flag", int'(per_flag), 0);

      // R5/R6 override with a live rate code
      write_cfg(1'b1, 1'b0, 3);
      read_flag();
      quiet_window(64, "R5 R6", 1'b1);
      chk(per_flag == 1'b0, "R6 flag", int'(per_flag), 0);
      n = 0;
      while (!sq_out) begin @(negedge clk); n++; end
      p = 0;
      do begin @(negedge clk); p++; end while (!(sq_out && p > 1) && p < 10);
      chk(p == 2, "R5 period", p, 2);

      // R8 strobe sets flag; R9 read clears, same-cycle event wins
      write_cfg(1'b0, 1'b1, 3);
      while (!per_strobe) @(negedge clk);
      @(negedge clk);
      chk(per_flag == 1'b1, "R8 flag set", int'(per_flag), 1);
      read_flag();
      chk(per_flag == 1'b0, "R9 read clears", int'(per_flag), 0);
      while (!per_strobe) @(negedge clk);
      flag_rd = 1'b1;
      @(negedge clk);
      flag_rd = 1'b0;
      chk(per_flag == 1'b1, "R9 set wins", int'(per_flag), 1);
      read_flag();
      chk(per_flag == 1'b0, "R9 second read", int'(per_flag), 0);

      // R10 rate change without restart
      write_cfg(1'b0, 1'b1, 15);
      repeat (37) @(negedge clk);
      write_cfg(1'b0, 1'b1, 3);
      wait_n = 0;
      while (!per_strobe && wait_n < 100) begin @(negedge clk); wait_n++; end
      chk(wait_n <= 8, "R10 first strobe", wait_n, 8);
      measure(p, h);
      chk(p == 8, "R10 period", p, 8);

      // Random mix
      for (int it = 0; it < 24; it++) begin
         bit ovr, en;
         code = int'($urandom_range(0, 9));
         en   = 1'($urandom_range(0, 1));
         ovr  = ($urandom_range(0, 3) == 0);
         if (ovr) begin
            write_cfg(1'b1, en, code);
            quiet_window(32, "R6 random", 1'b1);
         end else if (code == 0) begin
            write_cfg(1'b0, en, 0);
            quiet_window(64, "R4 random", 1'b0);
         end else begin
            run_code(code, en, (code < 3) ? "R3 random" : "R2 random");
         end
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule